// File: doc/BRIEF.md
# USB OTG event interrupt register

This block collects USB On-The-Go bus events into a sticky 16-bit status word and raises one active-high interrupt line. It watches decoded transceiver line states (J, K, SE0), VBUS and data-line pulse indications, a suspend flag, a one-cycle OTG timer expiry strobe, and six session/connection level signals. It also qualifies the raw line activity before it reaches the status word. SE0 must last a full 2 ms before it counts. A J-to-K transition counts as resume only while the device is suspended. A session request is taken from whichever pulse source the select input names.

Software reads the status word through a small register bus and clears bits by writing 1 to them. A second word on the same bus is an interrupt enable mask. The interrupt output is high while any enabled status bit is set. Line-state and pulse inputs cross into the clock domain through two-flop synchronisers. The other inputs must already be synchronous to `clk`.

Top module: `otg_evt_irq`

## Requirements
- R1: While `rst_n` is low and right after its release, the status word, the enable word and `irq` are all zero.
- R2: A one-cycle `timer_expired` strobe sets status bit 10, and the bit is readable on the cycle after the strobe's clock edge.
- R3: Status bit 9 sets once the synchronised SE0 has been high for CLK_KHZ*2 consecutive clock cycles (2 ms). A gap in SE0 restarts the count, and one unbroken SE0 period sets the bit at most once, even if software clears it while SE0 lasts.
- R4: Status bit 8 sets on a rising edge of the data-line pulse input when `srp_sel_dline` is 1, and on a rising edge of the VBUS pulse input when it is 0. A pulse on the unselected source leaves bit 8 unchanged.
- R5: Status bit 7 sets when the synchronised line state goes from J (J=1, K=0) to K (K=1, J=0) while `suspended` is 1. The same transition with `suspended` at 0 leaves bit 7 unchanged.
- R6: Status bit 6 sets when `suspended` rises. Bits 5 to 0 set on either edge of, in bit order from 5 down to 0, `rmt_conn`, `b_sess_vld`, `a_sess_vld`, `b_sess_end`, `a_vbus_vld` and `id_lvl`. Levels present when reset is released cause no event.
- R7: A write to address 0 (status) clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. Without such a write, no status bit ever clears. Address 1 holds the enable word, which reads back as written.
- R8: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Status bits 15 to 11 always read 0, even after a write of 1s to them.
- R10: `irq` is 1 exactly when some status bit and the matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_j | input | 1 | Decoded J line state, asynchronous |
| line_k | input | 1 | Decoded K line state, asynchronous |
| line_se0 | input | 1 | Decoded SE0 line state, asynchronous |
| vbus_pulse | input | 1 | VBUS pulsing indication, asynchronous |
| dline_pulse | input | 1 | Data-line pulsing indication, asynchronous |
| srp_sel_dline | input | 1 | Session-request source: 1 data line, 0 VBUS |
| suspended | input | 1 | Device is in the suspend state |
| timer_expired | input | 1 | One-cycle OTG timer expiry strobe |
| rmt_conn | input | 1 | Remote-connect level |
| b_sess_vld | input | 1 | B-session-valid level |
| a_sess_vld | input | 1 | A-session-valid level |
| b_sess_end | input | 1 | B-session-end level |
| a_vbus_vld | input | 1 | A-VBUS-valid level |
| id_lvl | input | 1 | ID pin level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 status, 1 enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The assertions assume that the suspend flag, the timer strobe, the source select and the six session levels are synchronous to the clock. They also assume the select does not change in the three cycles a pulse needs to cross the synchroniser, because the session-request check compares a past pulse level against the select in force when the event fired. The bench drives every input on the falling edge. It holds each line state and pulse for at least four cycles and moves the select only while both pulse inputs are low, so every event the assertions trace back can be found in the input history they inspect.

// File: rtl/otg_evt_pkg.sv
// Package: shared bit positions, widths and types for the OTG event register.
// Assumes: status bit order is fixed by software decoding and must not move.
package otg_evt_pkg;

    localparam int REG_W = 16;
    localparam int EV_W  = 11;
    localparam int CHG_W = 7;

    localparam int B_TMR  = 10;
    localparam int B_SE0  = 9;
    localparam int B_SRP  = 8;
    localparam int B_RSM  = 7;
    localparam int B_SUSP = 6;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;

    // Synchronised line-state and pulse bundle.
    typedef struct packed {
        logic j;
        logic k;
        logic se0;
        logic vbus;
        logic dline;
    } line_t;

    localparam int LINE_W = $bits(line_t);

endpackage

// File: rtl/otg_evt_sync.sv
// Module: two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level; bits are not sampled coherently.
module otg_evt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture into the local clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

endmodule

// File: rtl/otg_evt_se0_timer.sv
// Module: SE0 duration qualifier. Counts consecutive cycles of SE0 and
// fires once when the count reaches LIMIT; any non-SE0 cycle restarts it.
// Assumes: se0 is already synchronous; the counter saturates at LIMIT so
// a long SE0 period yields a single fire.
module otg_evt_se0_timer #(
    parameter int unsigned LIMIT = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0,
    output logic fire
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Saturating run-length counter of SE0 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!se0) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire = se0 && (cnt_q == CNT_LAST);

endmodule

// File: rtl/otg_evt_chg_det.sv
// Module: level-change detector. Each bit flags a change against its
// one-cycle delayed copy; bits marked in RISE_ONLY flag only a 0-to-1 edge.
// Assumes: inputs are synchronous; the first cycle after reset is masked
// so reset-time levels do not produce events.
module otg_evt_chg_det #(
    parameter int W = 7,
    parameter logic [W-1:0] RISE_ONLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] evt
);

    logic [W-1:0] lvl_q;
    logic         primed_q;

    // Delayed copy of the levels plus an armed flag after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            lvl_q    <= lvl;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RISE_ONLY[i]) begin : g_rise
            assign evt[i] = primed_q & lvl[i] & ~lvl_q[i];
        end else begin : g_any
            assign evt[i] = primed_q & (lvl[i] ^ lvl_q[i]);
        end
    end

endmodule

// File: rtl/otg_evt_qual.sv
// Module: event qualifiers. Turns synchronised line activity and the
// synchronous status inputs into one-cycle event pulses, one per status bit.
// Assumes: ln is synchronised; suspended, timer_expired, srp_sel_dline and
// chg_lvl are synchronous to clk.
module otg_evt_qual
    import otg_evt_pkg::*;
#(
    parameter int unsigned SE0_CYCLES = 96000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_t            ln,
    input  logic             srp_sel_dline,
    input  logic             suspended,
    input  logic             timer_expired,
    input  logic [CHG_W-2:0] chg_lvl,
    output logic [EV_W-1:0]  ev
);

    localparam logic [CHG_W-1:0] RISE_MASK = CHG_W'(1) << (CHG_W - 1);

    logic             se0_fire;
    logic             was_j_q;
    logic             vbus_q;
    logic             dline_q;
    logic             srp_evt;
    logic             rsm_evt;
    logic [CHG_W-1:0] chg_evt;

    otg_evt_se0_timer #(
        .LIMIT (SE0_CYCLES)
    ) u_se0 (
        .clk   (clk),
        .rst_n (rst_n),
        .se0   (ln.se0),
        .fire  (se0_fire)
    );

    otg_evt_chg_det #(
        .W         (CHG_W),
        .RISE_ONLY (RISE_MASK)
    ) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({suspended, chg_lvl}),
        .evt   (chg_evt)
    );

    // History of the J state and of both pulse sources for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_j_q <= 1'b0;
            vbus_q  <= 1'b0;
            dline_q <= 1'b0;
        end else begin
            was_j_q <= ln.j & ~ln.k;
            vbus_q  <= ln.vbus;
            dline_q <= ln.dline;
        end
    end

    // Session request from the selected pulse source, resume from J to K in suspend.
    always_comb begin
        srp_evt = srp_sel_dline ? (ln.dline & ~dline_q) : (ln.vbus & ~vbus_q);
        rsm_evt = suspended & was_j_q & ln.k & ~ln.j;
    end

    // Collect every event pulse in status bit order.
    always_comb begin
        ev              = '0;
        ev[CHG_W-1:0]   = chg_evt;
        ev[B_RSM]       = rsm_evt;
        ev[B_SRP]       = srp_evt;
        ev[B_SE0]       = se0_fire;
        ev[B_TMR]       = timer_expired;
    end

endmodule

// File: rtl/otg_evt_regs.sv
// Module: sticky status word with write-1-to-clear and an enable word.
// Assumes: an event in the same cycle as a clear of that bit wins; the
// upper status bits beyond EV_W are reserved and tied to zero.
module otg_evt_regs
    import otg_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] enable
);

    logic [EV_W-1:0]  st_q;
    logic [EV_W-1:0]  clr;
    logic [REG_W-1:0] en_q;

    // Clear mask from a status write.
    always_comb begin
        clr = (bus_wr && (bus_addr == ADDR_STATUS)) ? bus_wdata[EV_W-1:0] : '0;
    end

    // Sticky status update; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= (st_q & ~clr) | ev;
        end
    end

    // Enable word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr && (bus_addr == ADDR_ENABLE)) begin
            en_q <= bus_wdata;
        end
    end

    assign status = {{(REG_W - EV_W){1'b0}}, st_q};
    assign enable = en_q;

endmodule

// File: rtl/otg_evt_irq.sv
// Module: top of the OTG event interrupt register. Synchronises line
// inputs, qualifies events, holds status and enable, drives the interrupt.
// Assumes: CLK_KHZ is the clock frequency in kHz; SE0 qualification is
// 2 ms of that clock.
module otg_evt_irq
    import otg_evt_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 48000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_j,
    input  logic             line_k,
    input  logic             line_se0,
    input  logic             vbus_pulse,
    input  logic             dline_pulse,
    input  logic             srp_sel_dline,
    input  logic             suspended,
    input  logic             timer_expired,
    input  logic             rmt_conn,
    input  logic             b_sess_vld,
    input  logic             a_sess_vld,
    input  logic             b_sess_end,
    input  logic             a_vbus_vld,
    input  logic             id_lvl,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq
);

    localparam int unsigned SE0_CYCLES = CLK_KHZ * 2;

    line_t            ln_raw;
    line_t            ln_sync;
    logic [EV_W-1:0]  ev;
    logic [REG_W-1:0] status_w;
    logic [REG_W-1:0] enable_w;

    assign ln_raw = '{j: line_j, k: line_k, se0: line_se0,
                      vbus: vbus_pulse, dline: dline_pulse};

    otg_evt_sync #(
        .W (LINE_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ln_raw),
        .dout  (ln_sync)
    );

    otg_evt_qual #(
        .SE0_CYCLES (SE0_CYCLES)
    ) u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .ln            (ln_sync),
        .srp_sel_dline (srp_sel_dline),
        .suspended     (suspended),
        .timer_expired (timer_expired),
        .chg_lvl       ({rmt_conn, b_sess_vld, a_sess_vld,
                         b_sess_end, a_vbus_vld, id_lvl}),
        .ev            (ev)
    );

    otg_evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status_w),
        .enable    (enable_w)
    );

    // Read mux and combined interrupt.
    always_comb begin
        bus_rdata = (bus_addr == ADDR_ENABLE) ? enable_w : status_w;
        irq       = |(status_w & enable_w);
    end

endmodule

// File: rtl/otg_evt_irq_chk.sv
// Module: assertion checker for otg_evt_irq, attached by bind below.
// Assumes: synchronous inputs as described in the brief; the source
// select stays put while a pulse crosses the synchroniser.
module otg_evt_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        timer_expired,
    input logic        suspended,
    input logic        line_se0,
    input logic        vbus_pulse,
    input logic        dline_pulse,
    input logic        srp_sel_dline,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [15:0] bus_rdata,
    input logic [15:0] status,
    input logic        irq
);

    AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        timer_expired |=> status[10]); // R2

    AST_SE0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[9]) |-> $past(line_se0, 3)); // R3

    AST_SRP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[8]) |-> ($past(srp_sel_dline) ? $past(dline_pulse, 3)
                                                   : $past(vbus_pulse, 3))); // R4

    AST_RSM_SUSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended |=> !$rose(status[7])); // R5

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 1'b0)) |=> ((status & $past(status)) == $past(status))); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b0) |-> (bus_rdata[15:11] == 5'b0)); // R9

    AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 16'h0)); // R10

endmodule

bind otg_evt_irq otg_evt_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .timer_expired (timer_expired),
    .suspended     (suspended),
    .line_se0      (line_se0),
    .vbus_pulse    (vbus_pulse),
    .dline_pulse   (dline_pulse),
    .srp_sel_dline (srp_sel_dline),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .status        (status_w),
    .irq           (irq)
);

// File: tb/otg_evt_irq_tb_top.sv
`timescale 1ns/100ps
module otg_evt_irq_tb_top;

    localparam int unsigned KHZ = 8;
    localparam int unsigned LIM = KHZ * 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_j = 0, line_k = 0, line_se0 = 0;
    logic        vbus_pulse = 0, dline_pulse = 0, srp_sel_dline = 0;
    logic        suspended = 0, timer_expired = 0;
    logic        rmt_conn = 0, b_sess_vld = 0, a_sess_vld = 0;
    logic        b_sess_end = 0, a_vbus_vld = 0, id_lvl = 1;
    logic        bus_wr = 0, bus_addr = 0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    otg_evt_irq #(.CLK_KHZ(KHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_j(line_j), .line_k(line_k),
        .line_se0(line_se0), .vbus_pulse(vbus_pulse), .dline_pulse(dline_pulse),
        .srp_sel_dline(srp_sel_dline), .suspended(suspended),
        .timer_expired(timer_expired), .rmt_conn(rmt_conn),
        .b_sess_vld(b_sess_vld), .a_sess_vld(a_sess_vld),
        .b_sess_end(b_sess_end), .a_vbus_vld(a_vbus_vld), .id_lvl(id_lvl),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // Input history queues stand in for the synchroniser delay.
    logic [4:0]  hist[$];
    int          se0_run;
    bit          m_wasj, m_vb, m_dl, m_armed, m_susp_prev;
    logic [5:0]  m_lv_prev;
    logic [10:0] m_st;
    logic [15:0] m_en;

    always @(posedge clk) begin
        logic [10:0] ev;
        logic [4:0]  s;
        logic [5:0]  lv;
        lv = {rmt_conn, b_sess_vld, a_sess_vld, b_sess_end, a_vbus_vld, id_lvl};
        if (!rst_n) begin
            hist = {5'b0, 5'b0};
            se0_run = 0; m_wasj = 0; m_vb = 0; m_dl = 0; m_armed = 0;
            m_susp_prev = 0; m_lv_prev = '0; m_st = '0; m_en = '0;
        end else begin
            s  = hist[0];   // {j,k,se0,vbus,dline} as seen after two stages
            ev = '0;
            ev[10] = timer_expired;
            ev[9]  = s[2] && (se0_run == LIM - 1);
            ev[8]  = srp_sel_dline ? (s[0] && !m_dl) : (s[1] && !m_vb);
            ev[7]  = suspended && m_wasj && s[3] && !s[4];
            if (m_armed) begin
                ev[6] = suspended && !m_susp_prev;
                for (int i = 0; i < 6; i++) ev[i] = lv[i] != m_lv_prev[i];
            end
            if (bus_wr && !bus_addr) m_st = m_st & ~bus_wdata[10:0];
            m_st = m_st | ev;
            if (bus_wr && bus_addr) m_en = bus_wdata;
            se0_run = s[2] ? ((se0_run < LIM) ? se0_run + 1 : se0_run) : 0;
            m_wasj = s[4] && !s[3];
            m_vb = s[1]; m_dl = s[0];
            void'(hist.pop_front());
            hist.push_back({line_j, line_k, line_se0, vbus_pulse, dline_pulse});
            m_lv_prev = lv; m_susp_prev = suspended; m_armed = 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("model status/enable read (R7 R10)", bus_rdata,
                bus_addr ? m_en : {5'b0, m_st});
            chk("model irq (R10)", {15'b0, irq}, {15'b0, |({5'b0, m_st} & m_en)});
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 0; bus_addr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = 0; #0.1;
    endtask

    task automatic pulse_tmr;
        timer_expired = 1; tick(1); timer_expired = 0;
    endtask

    initial begin
        logic [15:0] v;
        tick(3);
        rd(0, v); chk("R1 status in reset", v, 16'h0);
        rd(1, v); chk("R1 enable in reset", v, 16'h0);
        chk("R1 irq in reset", {15'b0, irq}, 16'h0);
        rst_n = 1;
        tick(4);
        rd(0, v); chk("R1 R6 no event from reset levels", v, 16'h0);

        pulse_tmr;
        rd(0, v); chk("R2 timer sets bit 10", v, 16'h0400);
        wr(0, 16'h0000);
        rd(0, v); chk("R7 write 0 keeps bit", v, 16'h0400);
        wr(0, 16'h0400);
        rd(0, v); chk("R7 write 1 clears bit", v, 16'h0000);

        line_se0 = 1; tick(LIM - 4); line_se0 = 0; tick(1);
        line_se0 = 1; tick(LIM - 4); line_se0 = 0; tick(4);
        rd(0, v); chk("R3 short SE0 runs ignored", v, 16'h0000);
        line_se0 = 1; tick(LIM + 4);
        rd(0, v); chk("R3 2ms SE0 sets bit 9", v, 16'h0200);
        wr(0, 16'h0200); tick(2 * LIM);
        rd(0, v); chk("R3 one set per SE0 period", v, 16'h0000);
        line_se0 = 0; tick(4);

        srp_sel_dline = 0;
        dline_pulse = 1; tick(4); dline_pulse = 0; tick(4);
        rd(0, v); chk("R4 unselected data-line pulse ignored", v, 16'h0000);
        vbus_pulse = 1; tick(4); vbus_pulse = 0; tick(4);
        rd(0, v); chk("R4 VBUS pulse sets bit 8", v, 16'h0100);
        wr(0, 16'h0100);
        srp_sel_dline = 1; tick(2);
        vbus_pulse = 1; tick(4); vbus_pulse = 0; tick(4);
        rd(0, v); chk("R4 unselected VBUS pulse ignored", v, 16'h0000);
        dline_pulse = 1; tick(4); dline_pulse = 0; tick(4);
        rd(0, v); chk("R4 data-line pulse sets bit 8", v, 16'h0100);
        wr(0, 16'h0100);

        line_j = 1; tick(4); line_j = 0; line_k = 1; tick(4);
        rd(0, v); chk("R5 J to K outside suspend ignored", v, 16'h0000);
        line_k = 0; line_j = 1; tick(4);
        suspended = 1; tick(1);
        rd(0, v); chk("R6 suspend entry sets bit 6", v, 16'h0040);
        line_j = 0; line_k = 1; tick(4);
        rd(0, v); chk("R5 J to K in suspend sets bit 7", v, 16'h00C0);
        wr(0, 16'h00C0);
        suspended = 0; line_k = 0; tick(4);
        rd(0, v); chk("R6 suspend exit no event", v, 16'h0000);

        rmt_conn = 1; tick(1); rd(0, v); chk("R6 remote connect bit 5", v, 16'h0020);
        b_sess_vld = 1; tick(1); rd(0, v); chk("R6 B session valid bit 4", v, 16'h0030);
        a_sess_vld = 1; tick(1); rd(0, v); chk("R6 A session valid bit 3", v, 16'h0038);
        b_sess_end = 1; tick(1); rd(0, v); chk("R6 B session end bit 2", v, 16'h003C);
        a_vbus_vld = 1; tick(1); rd(0, v); chk("R6 A VBUS valid bit 1", v, 16'h003E);
        id_lvl = 0; tick(1); rd(0, v); chk("R6 ID falling edge bit 0", v, 16'h003F);
        wr(0, 16'h003F);
        rmt_conn = 0; tick(1); rd(0, v); chk("R6 falling edge bit 5", v, 16'h0020);

        wr(0, 16'hF800);
        rd(0, v); chk("R9 reserved bits read 0", v, 16'h0020);
        wr(0, 16'hFFFF);
        rd(0, v); chk("R7 clear all", v, 16'h0000);

        pulse_tmr;
        timer_expired = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 16'h0400;
        tick(1);
        timer_expired = 0; bus_wr = 0; bus_wdata = '0;
        rd(0, v); chk("R8 event beats clear", v, 16'h0400);
        wr(0, 16'h0400);

        wr(1, 16'h0400);
        rd(1, v); chk("R7 enable readback", v, 16'h0400);
        b_sess_vld = 0; tick(1);
        chk("R10 unenabled bit no irq", {15'b0, irq}, 16'h0);
        pulse_tmr;
        chk("R10 enabled bit raises irq", {15'b0, irq}, 16'h1);
        wr(0, 16'h0400);
        chk("R10 irq drops after clear", {15'b0, irq}, 16'h0);

        tick(4);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule